// File: doc/BRIEF.md
# Vertical Sync Phase Slew Controller

This block produces the vertical reference and the output field flag of a video timing generator. It runs free at a nominal field length until an input video signal is present. It then walks its own field timing onto the detected input field start, one field at a time, and does not jump to the new phase in one step. In every field it adds or removes a bounded number of lines, taking whichever direction is shorter, so the vertical reference never shows a runt or a doubled field while it pulls in.

The block works in units of lines. A one-cycle line strobe advances a line counter. A second pulse, which coincides with a strobe, marks the first line of an input field and carries that field's polarity. A presence flag says whether input video exists at all. The first input field start after presence is seen measures the phase. Every following output field boundary takes a bounded bite of the remaining error. When the error is used up, the locked flag rises exactly at a shared field start.

Top module: `vsync_phase_slew`

## Requirements
- R1: With `in_present` low, every output field lasts exactly FLEN lines. `vref` is high for lines 0 to VREF_LINES-1 of each field, and `out_field` inverts at every field start. Neither `vref` nor `out_field` changes except in the cycle after a line strobe.
- R2: During and right after reset, the line index is 0, so `vref` is 1, `out_field` is 0 and `locked` is 0.
- R3: The first `in_fstart` (sampled with `line_stb`) after `in_present` rises gives line index p, the internal line that begins with that strobe. The signed error is e = p when p <= FLEN/2 (integer division) and e = p - FLEN otherwise. If e = 0, `locked` rises at that same field start.
- R4: The internal field that contains the measurement keeps FLEN lines. Each later corrective field lasts FLEN + c lines, where c is the remaining error clamped to the range -STEP..+STEP. A positive error lengthens the field and a negative error shortens it.
- R5: The remaining error shrinks by |c| every field. The number of corrective fields is ceil(|e|/STEP), which is at most 8 for FLEN=313 and STEP=20.
- R6: When |e| > STEP, `out_field` keeps its value at the start of the first corrective field. When |e| <= STEP, it inverts at that start as usual.
- R7: `locked` rises at the field start that ends the last corrective field. That start coincides with an input field start. From then on, fields last FLEN lines and every output field start coincides with an input field start.
- R8: At the field start where `locked` rises, `out_field` takes the value of `in_fpol` sampled with that strobe.
- R9: When `in_present` is low at a clock edge, `locked` is 0 after that edge and any correction in progress is dropped. The field that follows the next boundary is nominal. A new measurement starts when `in_present` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse at the start of each line |
| in_fstart | input | 1 | Input field starts with this line (valid with `line_stb`) |
| in_fpol | input | 1 | Polarity of the input field that is running |
| in_present | input | 1 | Input video is present |
| vref | output | 1 | Vertical reference, high for the first VREF_LINES lines of a field |
| out_field | output | 1 | Output field polarity flag |
| locked | output | 1 | Output field timing coincides with the input |

## Verification
Two events can meet on the same strobe: a measurement that yields zero error, and the internal field wrap. The bench provokes this by placing the input field start exactly on internal line 0. It then expects the block to lock and take the input polarity at that very boundary, with no corrective field in between. A second collision comes from dropping presence in the cycle right after a corrective field has been loaded. The bench expects that already-loaded field to run out at its corrected length, and the next field to be nominal and unlocked.

// File: rtl/vsps_pkg.sv
package vsps_pkg;

   typedef enum logic [1:0] {
      ST_FREE = 2'd0,
      ST_SLEW = 2'd1,
      ST_LOCK = 2'd2
   } vsps_state_e;

   typedef enum logic [1:0] {
      POL_TOGGLE = 2'd0,
      POL_HOLD   = 2'd1,
      POL_TAKE   = 2'd2
   } vsps_pol_e;

endpackage

// File: rtl/vsps_line_counter.sv
module vsps_line_counter #(
   parameter int FLEN = 313,
   parameter int LW   = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_stb,
   input  logic [LW-1:0] load_len,
   output logic [LW-1:0] lcnt,
   output logic [LW-1:0] lcnt_next,
   output logic          wrap
);

   logic [LW-1:0] cur_len;
   logic          at_last;

   assign at_last   = (lcnt == cur_len - 1'b1);
   assign wrap      = line_stb && at_last;
   assign lcnt_next = at_last ? '0 : lcnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcnt    <= '0;
         cur_len <= LW'(FLEN);
      end else if (line_stb) begin
         lcnt <= lcnt_next;
         if (at_last) cur_len <= load_len;
      end
   end

endmodule

// File: rtl/vsps_phase_meas.sv
module vsps_phase_meas #(
   parameter int FLEN = 313,
   parameter int LW   = 9,
   parameter int EW   = 10
) (
   input  logic [LW-1:0]        pos,
   output logic signed [EW-1:0] err
);

   localparam int HALF = FLEN / 2;
   localparam logic signed [EW-1:0] FLEN_S = EW'(FLEN);

   logic signed [EW-1:0] pos_s;

   assign pos_s = $signed({1'b0, pos});
   assign err   = (pos > LW'(HALF)) ? (pos_s - FLEN_S) : pos_s;

endmodule

// File: rtl/vsps_slew_ctrl.sv
module vsps_slew_ctrl
   import vsps_pkg::*;
#(
   parameter int FLEN = 313,
   parameter int STEP = 20,
   parameter int LW   = 9,
   parameter int EW   = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_stb,
   input  logic                 wrap,
   input  logic                 present,
   input  logic                 fstart,
   input  logic signed [EW-1:0] err,
   output logic [LW-1:0]        next_len,
   output vsps_pol_e            pol_act,
   output logic                 locked
);

   localparam logic signed [EW-1:0] STEP_S = EW'(STEP);

   vsps_state_e          st;
   logic signed [EW-1:0] rem;
   logic signed [EW-1:0] adj;
   logic                 first;
   logic                 big_err;
   logic                 capture;

   assign capture = present && (st == ST_FREE) && line_stb && fstart;
   assign big_err = (err > STEP_S) || (err < -STEP_S);

   always_comb begin
      adj = '0;
      if (present && st == ST_SLEW) begin
         if (rem > STEP_S)       adj = STEP_S;
         else if (rem < -STEP_S) adj = -STEP_S;
         else                    adj = rem;
      end
   end

   assign next_len = LW'(FLEN + int'(adj));

   always_comb begin
      pol_act = POL_TOGGLE;
      if (!present)                           pol_act = POL_TOGGLE;
      else if (capture && err == '0)          pol_act = POL_TAKE;
      else if (st == ST_SLEW && rem == '0)    pol_act = POL_TAKE;
      else if (st == ST_SLEW && first)        pol_act = POL_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_FREE;
         rem   <= '0;
         first <= 1'b0;
      end else if (!present) begin
         st    <= ST_FREE;
         rem   <= '0;
         first <= 1'b0;
      end else begin
         case (st)
            ST_FREE: begin
               if (capture) begin
                  if (err == '0) begin
                     st <= ST_LOCK;
                  end else begin
                     st    <= ST_SLEW;
                     rem   <= err;
                     first <= big_err;
                  end
               end
            end
            ST_SLEW: begin
               if (wrap) begin
                  if (rem == '0) begin
                     st <= ST_LOCK;
                  end else begin
                     rem   <= rem - adj;
                     first <= 1'b0;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign locked = (st == ST_LOCK);

endmodule

// File: rtl/vsync_phase_slew.sv
module vsync_phase_slew
   import vsps_pkg::*;
#(
   parameter int FLEN       = 313,
   parameter int STEP       = 20,
   parameter int VREF_LINES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_stb,
   input  logic in_fstart,
   input  logic in_fpol,
   input  logic in_present,
   output logic vref,
   output logic out_field,
   output logic locked
);

   localparam int LW = $clog2(FLEN + STEP + 1);
   localparam int EW = LW + 1;

   if (FLEN < 4) begin : g_bad_flen
      $error("vsync_phase_slew: FLEN must be at least 4");
   end
   if (STEP < 1 || 2 * STEP >= FLEN) begin : g_bad_step
      $error("vsync_phase_slew: STEP must lie in 1..FLEN/2-1");
   end
   if (VREF_LINES < 1 || VREF_LINES >= FLEN - STEP) begin : g_bad_vref
      $error("vsync_phase_slew: VREF_LINES must fit in a shortened field");
   end

   logic [LW-1:0]        lcnt;
   logic [LW-1:0]        lcnt_next;
   logic [LW-1:0]        next_len;
   logic                 wrap;
   logic signed [EW-1:0] err;
   vsps_pol_e            pol_act;

   vsps_line_counter #(.FLEN(FLEN), .LW(LW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_stb  (line_stb),
      .load_len  (next_len),
      .lcnt      (lcnt),
      .lcnt_next (lcnt_next),
      .wrap      (wrap)
   );

   vsps_phase_meas #(.FLEN(FLEN), .LW(LW), .EW(EW)) u_meas (
      .pos (lcnt_next),
      .err (err)
   );

   vsps_slew_ctrl #(.FLEN(FLEN), .STEP(STEP), .LW(LW), .EW(EW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_stb (line_stb),
      .wrap     (wrap),
      .present  (in_present),
      .fstart   (in_fstart),
      .err      (err),
      .next_len (next_len),
      .pol_act  (pol_act),
      .locked   (locked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_field <= 1'b0;
      end else if (wrap) begin
         case (pol_act)
            POL_HOLD: out_field <= out_field;
            POL_TAKE: out_field <= in_fpol;
            default:  out_field <= ~out_field;
         endcase
      end
   end

   if (VREF_LINES == 1) begin : g_vref_single
      assign vref = (lcnt == '0);
   end else begin : g_vref_multi
      assign vref = (lcnt < LW'(VREF_LINES));
   end

endmodule

// File: rtl/vsps_checks.sv
module vsps_checks #(
   parameter int FLEN = 313,
   parameter int STEP = 20
) (
   input logic clk,
   input logic rst_n,
   input logic line_stb,
   input logic in_present,
   input logic vref,
   input logic out_field,
   input logic locked
);

   int   cnt;
   logic seen;
   logic vq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= 0;
         seen <= 1'b0;
         vq   <= 1'b1;
      end else begin
         vq <= vref;
         if (vref && !vq) begin
            if (seen) begin
               // R4: every field length stays inside the slew window
               a_r4_len_bound: assert (cnt >= FLEN - STEP && cnt <= FLEN + STEP)
                  else $error("field length %0d outside window", cnt);
            end
            seen <= 1'b1;
            cnt  <= line_stb ? 1 : 0;
         end else if (line_stb) begin
            cnt <= cnt + 1;
         end
      end
   end

   a_r1_quiet_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb |=> ($stable(vref) && $stable(out_field)));

   a_r1_flag_at_field_start: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_field) |-> $rose(vref));

   a_r7_lock_at_field_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $rose(vref));

   a_r9_drop_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      !in_present |=> !locked);

endmodule

bind vsync_phase_slew vsps_checks #(.FLEN(FLEN), .STEP(STEP)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_stb   (line_stb),
   .in_present (in_present),
   .vref       (vref),
   .out_field  (out_field),
   .locked     (locked)
);

// File: tb/vsync_phase_slew_tb.sv
module vsync_phase_slew_tb;

   localparam int FLEN = 313;
   localparam int STEP = 20;
   localparam int VW   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_stb = 1'b0;
   logic in_fstart = 1'b0;
   logic in_fpol = 1'b0;
   logic in_present = 1'b0;
   logic vref, out_field, locked;

   always #5 clk = ~clk;

   vsync_phase_slew #(.FLEN(FLEN), .STEP(STEP), .VREF_LINES(VW)) u_dut (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .in_fstart(in_fstart),
      .in_fpol(in_fpol), .in_present(in_present),
      .vref(vref), .out_field(out_field), .locked(locked)
   );

   typedef struct {
      int len;
      bit lk;
      bit al;
      bit of;
      bit ip;
   } rec_t;

   rec_t q[$];
   int   checks = 0;
   int   failures = 0;
   int   ilc = 0;
   int   mcnt = 0;
   bit   pv = 1'b1;
   bit   last_fs = 1'b0;
   bit   rise_now = 1'b0;
   bit   done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int err_of(input int p);
      return (p <= FLEN / 2) ? p : p - FLEN;
   endfunction

   function automatic int clamp(input int r);
      return (r > STEP) ? STEP : ((r < -STEP) ? -STEP : r);
   endfunction

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   // input video generator: a strobe every second cycle
   initial begin
      forever begin
         @(posedge clk); #2;
         line_stb  = 1'b1;
         in_fstart = in_present && (ilc == 0);
         if (ilc == 0) in_fpol = ~in_fpol;
         ilc = (ilc + 1) % FLEN;
         @(posedge clk); #2;
         line_stb  = 1'b0;
         in_fstart = 1'b0;
      end
   end

   // monitor: one record per output field start
   always @(negedge clk) begin
      rise_now = 1'b0;
      if (rst_n) begin
         if (vref && !pv) begin
            q.push_back('{len: mcnt, lk: locked, al: last_fs, of: out_field, ip: in_fpol});
            rise_now = 1'b1;
            mcnt = 0;
         end
         pv = vref;
         if (line_stb) begin
            mcnt++;
            last_fs = in_fstart;
         end
      end
   end

   task automatic wait_rise();
      do begin
         @(negedge clk); #1;
      end while (!rise_now);
   endtask

   task automatic run_trial(input int p, input bit drop);
      int e, k, rem, c, need;
      bit pre_of;
      in_present = 1'b0;
      wait_rise();
      wait_rise();
      pre_of = out_field;
      ilc = (FLEN + 1 - p) % FLEN;
      in_present = 1'b1;
      q.delete();
      e = err_of(p);
      k = (iabs(e) + STEP - 1) / STEP;
      if (drop) begin
         wait_rise();
         in_present = 1'b0;
         wait_rise();
         wait_rise();
         chk(q[1].len == FLEN + clamp(e), "R9 loaded field runs out", q[1].len, FLEN + clamp(e));
         chk(q[2].len == FLEN, "R9 nominal after drop", q[2].len, FLEN);
         chk(!q[1].lk && !q[2].lk, "R9 unlocked after drop", q[2].lk, 0);
         chk(q[2].of == !q[1].of, "R1 toggle in free run", q[2].of, !q[1].of);
         return;
      end
      need = (e == 0) ? 2 : k + 2;
      while (q.size() < need) wait_rise();
      if (e == 0) begin
         chk(q[0].lk, "R3 zero error locks at once", q[0].lk, 1);
         chk(q[0].al, "R3 lock on input start", q[0].al, 1);
         chk(q[0].len == FLEN, "R3 no correction", q[0].len, FLEN);
         chk(q[0].of == q[0].ip, "R8 take input polarity", q[0].of, q[0].ip);
         chk(q[1].len == FLEN && q[1].lk && q[1].al, "R7 stays aligned", q[1].len, FLEN);
         return;
      end
      chk(k <= 8, "R5 at most 8 fields", k, 8);
      chk(q[0].len == FLEN, "R4 measuring field nominal", q[0].len, FLEN);
      chk(!q[0].lk, "R4 not locked yet", q[0].lk, 0);
      if (iabs(e) > STEP)
         chk(q[0].of == pre_of, "R6 polarity repeated", q[0].of, pre_of);
      else
         chk(q[0].of == !pre_of, "R6 polarity toggled", q[0].of, !pre_of);
      rem = e;
      for (int j = 1; j <= k; j++) begin
         c = clamp(rem);
         rem -= c;
         chk(q[j].len == FLEN + c, "R4 corrective length", q[j].len, FLEN + c);
         chk(q[j].lk == (j == k), "R5 lock after last step", q[j].lk, (j == k));
         if (j < k)
            chk(q[j].of == !q[j-1].of, "R1 toggle while slewing", q[j].of, !q[j-1].of);
      end
      chk(q[k].al, "R7 lock coincides with input start", q[k].al, 1);
      chk(q[k].of == q[k].ip, "R8 take input polarity", q[k].of, q[k].ip);
      chk(q[k+1].len == FLEN && q[k+1].lk && q[k+1].al, "R7 locked field nominal and aligned",
          q[k+1].len, FLEN);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int rp;
      void'($urandom(32'd20240611));
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(vref == 1'b1, "R2 vref at reset", vref, 1);
      chk(out_field == 1'b0, "R2 field flag at reset", out_field, 0);
      chk(locked == 1'b0, "R2 unlocked at reset", locked, 0);

      q.delete();
      while (q.size() < 3) wait_rise();
      for (int j = 1; j < 3; j++) begin
         chk(q[j].len == FLEN, "R1 free field length", q[j].len, FLEN);
         chk(q[j].of == !q[j-1].of, "R1 toggle per field", q[j].of, !q[j-1].of);
         chk(!q[j].lk, "R1 unlocked when absent", q[j].lk, 0);
      end
      // vref width: VW lines high after a field start
      wait_rise();
      repeat (2 * VW - 1) @(negedge clk);
      chk(vref == 1'b1, "R1 vref last high line", vref, 1);
      repeat (2) @(negedge clk);
      chk(vref == 1'b0, "R1 vref low after width", vref, 0);

      run_trial(0, 1'b0);
      run_trial(20, 1'b0);
      run_trial(21, 1'b0);
      run_trial(156, 1'b0);
      run_trial(157, 1'b0);
      run_trial(FLEN - 20, 1'b0);
      run_trial(FLEN - 1, 1'b0);
      for (int t = 0; t < 4; t++) begin
         rp = $urandom_range(FLEN - 1, 0);
         run_trial(rp, 1'b0);
      end
      run_trial(100, 1'b1);
      run_trial(60, 1'b0);

      // R9: drop presence mid-field while locked
      repeat (7) @(negedge clk);
      chk(locked == 1'b1, "R9 locked before drop", locked, 1);
      #1 in_present = 1'b0;
      @(negedge clk);
      chk(locked == 1'b0, "R9 unlock after drop", locked, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule